// File: doc/BRIEF.md
# Error Signaling Classifier

This block takes one error event reported by a function and turns it into status updates and at most one outgoing error message. An event carries a 32-bit error vector, a flag saying whether it is correctable, a flag saying a non-fatal error may be treated as advisory, and a 16-bit source ID. The block checks that the event names exactly one supported error and picks its severity from a programmable register. It then sets the device-level and per-error status bits, applies the mask and reporting-enable bits, and emits a correctable, non-fatal or fatal message tagged with the source ID.

Events enter one at a time through a valid/ready handshake. When an uncorrectable or advisory error has to be logged, the block pulses a request toward an external header-log block and names the error's bit index. In the same cycle that block answers whether its log overflowed. An overflow on an event that sends a message produces a follow-on correctable header-log-overflow message. Software reaches the mask, severity, enable and status registers through a simple single-cycle register port.

Top module: `err_signal_classifier`

## Requirements
- R1: After reset the uncorrectable status, uncorrectable mask, correctable status, control and device status registers are zero, the correctable mask holds 0x00002000, evReady is 1 and msgValid is 0.
- R2: The event vector is ANDed with the supported set (uncorrectable 0x03FFF030, correctable 0x0000F1C1). If the result does not have exactly one bit set, no register changes, logReq stays low and no message is sent.
- R3: An uncorrectable error is fatal when its bit in the severity register (address 2) is 1 and non-fatal otherwise. The severity register resets to 0x00462030, which makes bits 4, 5, 13, 17, 18 and 22 fatal.
- R4: A correctable error sets device status bit 0 and its correctable status bit. When its correctable mask bit (address 4) is set, no message is sent. Otherwise a message with severity code 01 is sent only when control bit 0 is 1.
- R5: An uncorrectable error sets device status bit 2 (fatal) or bit 1 (non-fatal). When its uncorrectable mask bit (address 1) is set, only its status bit is set: no log request and no message.
- R6: An unmasked uncorrectable error raises logReq with logIdx equal to its bit number and sets its status bit. A fatal message (code 11) is sent when control bit 4 (system-error enable) or bit 2 is set. A non-fatal message (code 10) is sent when control bit 4 or bit 1 is set.
- R7: The unsupported-request error (uncorrectable bit 20) also sets device status bit 3. When control bit 3 (UR reporting) is 0, its message is suppressed: always on the correctable path, and on the uncorrectable path only when control bit 4 is also 0.
- R8: A non-fatal error with evAdvisory set takes the correctable path using correctable bit 13. When bit 13 is not masked, it requests a log only if its uncorrectable mask bit is clear, and it sets its uncorrectable status bit.
- R9: When logOverflow is 1 during a log request whose event sends a message, a follow-on correctable event for bit 15 is processed with source ID 0. Its message, if any, comes one cycle after the first message.
- R10: evReady is high only while idle. logReq is valid in the cycle after acceptance. msgValid is a one-cycle pulse one cycle after that, carrying msgSev and msgSource.
- R11: Writing to addresses 0, 3 and 6 clears the status bits written as 1. Addresses 1, 2 and 4 store the written value ANDed with the supported set, and address 5 stores the low 5 bits. Status bits change only on an event or on such a clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| evValid | input | 1 | Event offered |
| evReady | output | 1 | Block can accept an event |
| evStatus | input | 32 | Error vector |
| evCorrectable | input | 1 | Event is correctable |
| evAdvisory | input | 1 | Non-fatal event may be advisory |
| evSource | input | SRC_W | Requester source ID |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 3 | Register address |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Register read data (combinational) |
| logReq | output | 1 | Request to log the current error |
| logIdx | output | 5 | Bit number of the error to log |
| logOverflow | input | 1 | Header-log block reports overflow |
| msgValid | output | 1 | Error message pulse |
| msgSev | output | 2 | 01 correctable, 10 non-fatal, 11 fatal |
| msgSource | output | SRC_W | Source ID of the message |

## Verification
An event accepted at clock edge N shows its log request between edges N and N+1. Its status registers and message become visible after edge N+1, and a follow-on overflow message appears after edge N+2. The bench drives every input on the falling edge and samples in the following falling-edge window, so each check lands in the half-cycle where the result is due. It also checks that msgValid is low again one cycle later. Register readback is taken only once the event has fully retired.

// File: rtl/erc_pkg.sv
package erc_pkg;
  localparam int STATUS_W = 32;
  localparam int IDX_W = $clog2(STATUS_W);

  localparam logic [STATUS_W-1:0] UNC_SUPPORTED   = 32'h03FF_F030;
  localparam logic [STATUS_W-1:0] UNC_SEV_DEFAULT = 32'h0046_2030;
  localparam logic [STATUS_W-1:0] COR_SUPPORTED   = 32'h0000_F1C1;
  localparam logic [STATUS_W-1:0] COR_MASK_RESET  = 32'h0000_2000;

  localparam int UR_BIT       = 20;
  localparam int ADVISORY_BIT = 13;
  localparam int HDR_OVF_BIT  = 15;

  // control register bits
  localparam int CTL_COR_EN   = 0;
  localparam int CTL_NF_EN    = 1;
  localparam int CTL_FATAL_EN = 2;
  localparam int CTL_UR_EN    = 3;
  localparam int CTL_SERR_EN  = 4;
  localparam int CTL_W        = 5;

  // device status bits
  localparam int DEV_COR   = 0;
  localparam int DEV_NF    = 1;
  localparam int DEV_FATAL = 2;
  localparam int DEV_UR    = 3;
  localparam int DEV_W     = 4;

  localparam logic [2:0] ADR_UNC_STAT = 3'd0;
  localparam logic [2:0] ADR_UNC_MASK = 3'd1;
  localparam logic [2:0] ADR_UNC_SEV  = 3'd2;
  localparam logic [2:0] ADR_COR_STAT = 3'd3;
  localparam logic [2:0] ADR_COR_MASK = 3'd4;
  localparam logic [2:0] ADR_CTL      = 3'd5;
  localparam logic [2:0] ADR_DEV_STAT = 3'd6;

  typedef enum logic [1:0] {
    SEV_NONE     = 2'b00,
    SEV_COR      = 2'b01,
    SEV_NONFATAL = 2'b10,
    SEV_FATAL    = 2'b11
  } sev_e;

  typedef enum logic {ST_IDLE, ST_EVAL} ctrlState_e;

  typedef struct packed {
    logic loadEv;
    logic loadOvf;
    logic commit;
  } strobes_t;
endpackage

// File: rtl/erc_ctrl.sv
module erc_ctrl
  import erc_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     evValid,
  input  logic     ovfHit,
  output logic     evReady,
  output strobes_t strobes
);
  ctrlState_e state, stateNext;

  always_comb begin
    evReady         = (state == ST_IDLE);
    strobes.loadEv  = (state == ST_IDLE) && evValid;
    strobes.commit  = (state == ST_EVAL);
    strobes.loadOvf = (state == ST_EVAL) && ovfHit;
    stateNext = state;
    case (state)
      ST_IDLE: if (evValid) stateNext = ST_EVAL;
      ST_EVAL: stateNext = ovfHit ? ST_EVAL : ST_IDLE;
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  assert_accept_then_busy_R10: assert property (@(posedge clk) disable iff (!rstN)
    (evValid && evReady) |=> !evReady);
endmodule

// File: rtl/erc_datapath.sv
module erc_datapath
  import erc_pkg::*;
#(
  parameter int SRC_W = 16
) (
  input  logic                clk,
  input  logic                rstN,
  input  strobes_t            strobes,
  input  logic [STATUS_W-1:0] evStatus,
  input  logic                evCorrectable,
  input  logic                evAdvisory,
  input  logic [SRC_W-1:0]    evSource,
  input  logic                regWrEn,
  input  logic [2:0]          regAddr,
  input  logic [STATUS_W-1:0] regWrData,
  output logic [STATUS_W-1:0] regRdData,
  input  logic                logOverflow,
  output logic                logReq,
  output logic [IDX_W-1:0]    logIdx,
  output logic                ovfHit,
  output logic                msgValid,
  output logic [1:0]          msgSev,
  output logic [SRC_W-1:0]    msgSource
);
  // captured event
  logic [STATUS_W-1:0] curStatus;
  logic                curCor;
  logic                curAdv;
  logic [SRC_W-1:0]    curSrc;

  // registers
  logic [STATUS_W-1:0] uncStatus, uncMask, uncSev, corStatus, corMask;
  logic [CTL_W-1:0]    ctl;
  logic [DEV_W-1:0]    devStatus;

  // decision
  logic [STATUS_W-1:0] sel, corBit, uncBit, corSet, uncSet;
  logic [DEV_W-1:0]    devSet;
  logic                oneHot, isUr, isFatal, toCor, doLog, doSend;
  sev_e                sev;

  function automatic logic [IDX_W-1:0] bitIndex(input logic [STATUS_W-1:0] v);
    bitIndex = '0;
    for (int i = 0; i < STATUS_W; i++)
      if (v[i]) bitIndex = IDX_W'(i);
  endfunction

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curStatus <= '0;
      curCor    <= 1'b0;
      curAdv    <= 1'b0;
      curSrc    <= '0;
    end else if (strobes.loadEv) begin
      curStatus <= evStatus;
      curCor    <= evCorrectable;
      curAdv    <= evAdvisory;
      curSrc    <= evSource;
    end else if (strobes.loadOvf) begin
      curStatus <= STATUS_W'(1) << HDR_OVF_BIT;
      curCor    <= 1'b1;
      curAdv    <= 1'b0;
      curSrc    <= '0;
    end
  end

  always_comb begin
    sel     = curStatus & (curCor ? COR_SUPPORTED : UNC_SUPPORTED);
    oneHot  = (sel != '0) && ((sel & (sel - STATUS_W'(1))) == '0);
    isUr    = !curCor && sel[UR_BIT];
    isFatal = !curCor && ((sel & uncSev) != '0);
    toCor   = curCor || (!isFatal && curAdv);
    corBit  = curCor ? sel : (STATUS_W'(1) << ADVISORY_BIT);
    uncBit  = curCor ? '0 : sel;
    devSet  = '0;
    corSet  = '0;
    uncSet  = '0;
    doLog   = 1'b0;
    doSend  = 1'b0;
    sev     = SEV_NONE;
    if (oneHot) begin
      devSet[DEV_UR] = isUr;
      if (toCor) begin
        devSet[DEV_COR] = 1'b1;
        corSet = corBit;
        if ((corMask & corBit) == '0) begin
          if (!curCor) begin
            doLog  = ((uncMask & uncBit) == '0);
            uncSet = uncBit;
          end
          doSend = ctl[CTL_COR_EN] && !(isUr && !ctl[CTL_UR_EN]);
          sev    = SEV_COR;
        end
      end else begin
        devSet[DEV_FATAL] = isFatal;
        devSet[DEV_NF]    = !isFatal;
        uncSet = uncBit;
        if ((uncMask & uncBit) == '0) begin
          doLog  = 1'b1;
          doSend = !(isUr && !ctl[CTL_UR_EN] && !ctl[CTL_SERR_EN]) &&
                   (ctl[CTL_SERR_EN] || (isFatal ? ctl[CTL_FATAL_EN] : ctl[CTL_NF_EN]));
          sev    = isFatal ? SEV_FATAL : SEV_NONFATAL;
        end
      end
    end
    if (!doSend) sev = SEV_NONE;
  end

  assign logReq = strobes.commit && doLog;
  assign logIdx = bitIndex(uncBit);
  assign ovfHit = doLog && doSend && logOverflow;

  // register file
  logic wrUncStat, wrCorStat, wrDevStat;
  assign wrUncStat = regWrEn && (regAddr == ADR_UNC_STAT);
  assign wrCorStat = regWrEn && (regAddr == ADR_COR_STAT);
  assign wrDevStat = regWrEn && (regAddr == ADR_DEV_STAT);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      uncStatus <= '0;
      uncMask   <= '0;
      uncSev    <= UNC_SEV_DEFAULT;
      corStatus <= '0;
      corMask   <= COR_MASK_RESET;
      ctl       <= '0;
      devStatus <= '0;
      msgValid  <= 1'b0;
      msgSev    <= SEV_NONE;
      msgSource <= '0;
    end else begin
      uncStatus <= (uncStatus & ~(wrUncStat ? regWrData : '0)) | (strobes.commit ? uncSet : '0);
      corStatus <= (corStatus & ~(wrCorStat ? regWrData : '0)) | (strobes.commit ? corSet : '0);
      devStatus <= (devStatus & ~(wrDevStat ? regWrData[DEV_W-1:0] : '0)) |
                   (strobes.commit ? devSet : '0);
      if (regWrEn) begin
        case (regAddr)
          ADR_UNC_MASK: uncMask <= regWrData & UNC_SUPPORTED;
          ADR_UNC_SEV:  uncSev  <= regWrData & UNC_SUPPORTED;
          ADR_COR_MASK: corMask <= regWrData & COR_SUPPORTED;
          ADR_CTL:      ctl     <= regWrData[CTL_W-1:0];
          default: ;
        endcase
      end
      msgValid  <= strobes.commit && doSend;
      msgSev    <= (strobes.commit && doSend) ? sev : SEV_NONE;
      msgSource <= (strobes.commit && doSend) ? curSrc : '0;
    end
  end

  always_comb begin
    case (regAddr)
      ADR_UNC_STAT: regRdData = uncStatus;
      ADR_UNC_MASK: regRdData = uncMask;
      ADR_UNC_SEV:  regRdData = uncSev;
      ADR_COR_STAT: regRdData = corStatus;
      ADR_COR_MASK: regRdData = corMask;
      ADR_CTL:      regRdData = STATUS_W'(ctl);
      ADR_DEV_STAT: regRdData = STATUS_W'(devStatus);
      default:      regRdData = '0;
    endcase
  end

  assert_msg_after_commit_R10: assert property (@(posedge clk) disable iff (!rstN)
    msgValid |-> $past(strobes.commit));
  assert_msg_sev_known_R6: assert property (@(posedge clk) disable iff (!rstN)
    msgValid |-> (msgSev != SEV_NONE));
  assert_log_unmasked_R5: assert property (@(posedge clk) disable iff (!rstN)
    logReq |-> ((uncMask & (STATUS_W'(1) << logIdx)) == '0));
  assert_dev_stable_R11: assert property (@(posedge clk) disable iff (!rstN)
    (!strobes.commit && !wrDevStat) |=> $stable(devStatus));
  assert_unc_sticky_R11: assert property (@(posedge clk) disable iff (!rstN)
    !wrUncStat |=> ((uncStatus & $past(uncStatus)) == $past(uncStatus)));
endmodule

// File: rtl/err_signal_classifier.sv
module err_signal_classifier
  import erc_pkg::*;
#(
  parameter int SRC_W = 16
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                evValid,
  output logic                evReady,
  input  logic [STATUS_W-1:0] evStatus,
  input  logic                evCorrectable,
  input  logic                evAdvisory,
  input  logic [SRC_W-1:0]    evSource,
  input  logic                regWrEn,
  input  logic [2:0]          regAddr,
  input  logic [STATUS_W-1:0] regWrData,
  output logic [STATUS_W-1:0] regRdData,
  output logic                logReq,
  output logic [IDX_W-1:0]    logIdx,
  input  logic                logOverflow,
  output logic                msgValid,
  output logic [1:0]          msgSev,
  output logic [SRC_W-1:0]    msgSource
);
  strobes_t strobes;
  logic     ovfHit;

  erc_ctrl uCtrl (
    .clk     (clk),
    .rstN    (rstN),
    .evValid (evValid),
    .ovfHit  (ovfHit),
    .evReady (evReady),
    .strobes (strobes)
  );

  erc_datapath #(.SRC_W(SRC_W)) uDp (
    .clk           (clk),
    .rstN          (rstN),
    .strobes       (strobes),
    .evStatus      (evStatus),
    .evCorrectable (evCorrectable),
    .evAdvisory    (evAdvisory),
    .evSource      (evSource),
    .regWrEn       (regWrEn),
    .regAddr       (regAddr),
    .regWrData     (regWrData),
    .regRdData     (regRdData),
    .logOverflow   (logOverflow),
    .logReq        (logReq),
    .logIdx        (logIdx),
    .ovfHit        (ovfHit),
    .msgValid      (msgValid),
    .msgSev        (msgSev),
    .msgSource     (msgSource)
  );
endmodule

// File: tb/err_signal_classifier_test.sv
`timescale 1ns/1ps
module err_signal_classifier_test;
  localparam logic [31:0] UNC_SUP = 32'h03FF_F030;
  localparam logic [31:0] COR_SUP = 32'h0000_F1C1;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        evValid = 1'b0, evCorrectable = 1'b0, evAdvisory = 1'b0;
  logic [31:0] evStatus = '0;
  logic [15:0] evSource = '0;
  logic        regWrEn = 1'b0;
  logic [2:0]  regAddr = '0;
  logic [31:0] regWrData = '0;
  logic        logOverflow = 1'b0;
  logic        evReady, logReq, msgValid;
  logic [31:0] regRdData;
  logic [4:0]  logIdx;
  logic [1:0]  msgSev;
  logic [15:0] msgSource;

  err_signal_classifier uut (
    .clk(clk), .rstN(rstN), .evValid(evValid), .evReady(evReady),
    .evStatus(evStatus), .evCorrectable(evCorrectable), .evAdvisory(evAdvisory),
    .evSource(evSource), .regWrEn(regWrEn), .regAddr(regAddr), .regWrData(regWrData),
    .regRdData(regRdData), .logReq(logReq), .logIdx(logIdx), .logOverflow(logOverflow),
    .msgValid(msgValid), .msgSev(msgSev), .msgSource(msgSource)
  );

  always #10 clk = ~clk;

  int nChecks = 0, nFail = 0;
  bit done = 0;

  // model state
  logic [31:0] mUnc, mUncMask, mSev, mCor, mCorMask;
  logic [4:0]  mCtl;
  logic [3:0]  mDev;
  // prediction
  bit          eLog, eSend;
  logic [1:0]  eSev;
  logic [4:0]  eIdx;
  string       eReq;

  task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic readReg(input logic [2:0] a, output logic [31:0] d);
    regAddr = a;
    #1;
    d = regRdData;
  endtask

  task automatic checkRegs(input string req);
    logic [31:0] d;
    readReg(3'd0, d); check(req, "unc status", d, mUnc);
    readReg(3'd1, d); check(req, "unc mask", d, mUncMask);
    readReg(3'd2, d); check(req, "severity", d, mSev);
    readReg(3'd3, d); check(req, "cor status", d, mCor);
    readReg(3'd4, d); check(req, "cor mask", d, mCorMask);
    readReg(3'd5, d); check(req, "control", d, 32'(mCtl));
    readReg(3'd6, d); check(req, "dev status", d, 32'(mDev));
  endtask

  task automatic regWrite(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(posedge clk);
    #1 regWrEn = 1'b0;
    case (a)
      3'd0: mUnc &= ~d;
      3'd1: mUncMask = d & UNC_SUP;
      3'd2: mSev = d & UNC_SUP;
      3'd3: mCor &= ~d;
      3'd4: mCorMask = d & COR_SUP;
      3'd5: mCtl = d[4:0];
      3'd6: mDev &= ~d[3:0];
      default: ;
    endcase
  endtask

  task automatic predict(input logic [31:0] st, input bit c, input bit a);
    logic [31:0] sel, bitv;
    bit ur, fat, toc;
    sel = st & (c ? COR_SUP : UNC_SUP);
    eLog = 0; eSend = 0; eSev = 2'b00; eIdx = '0; eReq = "R2";
    if ($countones(sel) != 1) return;
    for (int i = 0; i < 32; i++) if (sel[i]) eIdx = 5'(i);
    ur  = !c && sel[20];
    fat = !c && ((sel & mSev) != 0);
    toc = c || (!fat && a);
    if (ur) mDev[3] = 1'b1;
    if (toc) begin
      bitv = c ? sel : 32'h0000_2000;
      eReq = ur ? "R7" : (c ? "R4" : "R8");
      mDev[0] = 1'b1;
      if ((mCorMask & bitv) == 0) begin
        if (!c) begin
          eLog = ((mUncMask & sel) == 0);
          mUnc |= sel;
        end
        eSend = mCtl[0] && !(ur && !mCtl[3]);
      end
      mCor |= bitv;
      if (eSend) eSev = 2'b01;
    end else begin
      eReq = ur ? "R7" : (fat ? "R3" : "R6");
      if (fat) mDev[2] = 1'b1; else mDev[1] = 1'b1;
      if ((mUncMask & sel) != 0) eReq = "R5";
      else begin
        eLog = 1;
        eSend = !(ur && !mCtl[3] && !mCtl[4]) && (mCtl[4] || (fat ? mCtl[2] : mCtl[1]));
      end
      mUnc |= sel;
      if (eSend) eSev = fat ? 2'b11 : 2'b10;
    end
  endtask

  task automatic runEvent(input logic [31:0] st, input bit c, input bit a,
                          input logic [15:0] src, input bit ovf);
    bit firstSend, follow;
    @(negedge clk);
    check("R10", "ready idle", 32'(evReady), 32'd1);
    evValid = 1'b1; evStatus = st; evCorrectable = c; evAdvisory = a; evSource = src;
    @(posedge clk);
    @(negedge clk);
    evValid = 1'b0; logOverflow = ovf;
    predict(st, c, a);
    check("R10", "ready busy", 32'(evReady), 32'd0);
    check(eReq, "logReq", 32'(logReq), 32'(eLog));
    if (eLog) check("R6", "logIdx", 32'(logIdx), 32'(eIdx));
    firstSend = eSend;
    follow = eSend && eLog && ovf;
    @(posedge clk);
    @(negedge clk);
    logOverflow = 1'b0;
    check(eReq, "msgValid", 32'(msgValid), 32'(eSend));
    check(eReq, "msgSev", 32'(msgSev), 32'(eSev));
    check(eReq, "msgSource", 32'(msgSource), firstSend ? 32'(src) : 32'd0);
    if (follow) begin
      predict(32'h0000_8000, 1'b1, 1'b0);
      @(posedge clk);
      @(negedge clk);
      check("R9", "ovf msgValid", 32'(msgValid), 32'(eSend));
      check("R9", "ovf msgSev", 32'(msgSev), 32'(eSev));
      check("R9", "ovf source", 32'(msgSource), 32'd0);
    end
    @(negedge clk);
    check("R10", "pulse ended", 32'(msgValid), 32'd0);
    checkRegs(follow ? "R9" : eReq);
  endtask

  initial begin
    logic [31:0] d;
    void'($urandom(32'd4242));
    mUnc = 0; mUncMask = 0; mSev = 32'h0046_2030; mCor = 0; mCorMask = 32'h0000_2000;
    mCtl = 0; mDev = 0;
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    @(negedge clk);
    // R1 reset state, R3 default severity
    check("R1", "evReady", 32'(evReady), 32'd1);
    check("R1", "msgValid", 32'(msgValid), 32'd0);
    readReg(3'd2, d); check("R3", "default severity", d, 32'h0046_2030);
    checkRegs("R1");

    // R2 invalid vectors: none, two bits, unsupported only
    regWrite(3'd5, 32'h1F);
    runEvent(32'h0, 1'b0, 1'b0, 16'h1111, 1'b0);
    runEvent(32'h0000_3000, 1'b0, 1'b0, 16'h1112, 1'b0);
    runEvent(32'h0000_0002, 1'b0, 1'b0, 16'h1113, 1'b0);
    runEvent(32'h0000_0041, 1'b1, 1'b0, 16'h1114, 1'b0);
    // R3 default fatal (bit 4) and non-fatal (bit 12), then reprogrammed
    runEvent(32'h0000_0010, 1'b0, 1'b0, 16'h2001, 1'b0);
    runEvent(32'h0000_1000, 1'b0, 1'b0, 16'h2002, 1'b0);
    regWrite(3'd2, 32'h0000_1000);
    runEvent(32'h0000_1000, 1'b0, 1'b0, 16'h2003, 1'b0);
    regWrite(3'd2, 32'h0046_2030);
    // R4 correctable unmasked then masked
    runEvent(32'h0000_0001, 1'b1, 1'b0, 16'h3001, 1'b0);
    regWrite(3'd4, 32'h0000_0040);
    runEvent(32'h0000_0040, 1'b1, 1'b0, 16'h3002, 1'b0);
    // R5 masked uncorrectable
    regWrite(3'd1, 32'h0000_4000);
    runEvent(32'h0000_4000, 1'b0, 1'b0, 16'h4001, 1'b0);
    // R7 unsupported request with UR and system-error enables off, then system-error on
    regWrite(3'd1, 32'h0);
    regWrite(3'd5, 32'h07);
    runEvent(32'h0010_0000, 1'b0, 1'b0, 16'h5001, 1'b0);
    regWrite(3'd5, 32'h17);
    runEvent(32'h0010_0000, 1'b0, 1'b0, 16'h5002, 1'b0);
    // R7 advisory unsupported request on correctable path with UR off
    regWrite(3'd4, 32'h0);
    runEvent(32'h0010_0000, 1'b0, 1'b1, 16'h5003, 1'b0);
    // R8 advisory non-fatal, uncorrectable mask clear then set
    regWrite(3'd5, 32'h0F);
    runEvent(32'h0000_4000, 1'b0, 1'b1, 16'h6001, 1'b0);
    regWrite(3'd1, 32'h0000_4000);
    runEvent(32'h0000_4000, 1'b0, 1'b1, 16'h6002, 1'b0);
    regWrite(3'd1, 32'h0);
    // R9 overflow follow-on
    runEvent(32'h0000_1000, 1'b0, 1'b0, 16'h7001, 1'b1);
    // R11 clears
    regWrite(3'd0, 32'hFFFF_FFFF);
    regWrite(3'd3, 32'h0000_0001);
    regWrite(3'd6, 32'h0000_000F);
    regWrite(3'd1, 32'hFFFF_FFFF);
    @(negedge clk);
    checkRegs("R11");

    // constrained random
    for (int n = 0; n < 400; n++) begin
      logic [31:0] st;
      int k;
      if ($urandom % 4 == 0) begin
        regWrite(3'd5, $urandom);
        regWrite(3'd1, $urandom & $urandom & $urandom);
        regWrite(3'd2, $urandom);
        regWrite(3'd4, $urandom & $urandom);
      end
      if ($urandom % 3 == 0) begin
        regWrite(3'd0, $urandom);
        regWrite(3'd3, $urandom);
        regWrite(3'd6, $urandom);
      end
      k = $urandom % 8;
      if (k == 0)      st = 32'h0;
      else if (k == 1) st = (32'h1 << ($urandom % 32)) | (32'h1 << ($urandom % 32));
      else if (k == 2) st = 32'h1 << (12 + $urandom % 14);
      else             st = 32'h1 << ($urandom % 32);
      runEvent(st, 1'(($urandom % 3) == 0), 1'($urandom), 16'($urandom), 1'($urandom));
    end

    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      nChecks++; nFail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
      $finish;
    end
  end
endmodule